// File: doc/BRIEF.md
# Pipelined Multi-Operand Summation Tree

This block adds `N` unsigned operands of `W` bits each and returns their exact sum as one ordinary binary word. The operands arrive together on one flat input bus, qualified by a valid strobe. Inside, the words are kept in redundant carry-save form. Each stage of the tree takes groups of four words and reduces each group to two with a four-to-two compressor. A compressor is two chained full-adder rows. If three words are left over, a single full-adder row reduces them to two. If one or two are left over, they pass through unchanged.

Every stage ends in a register, and so does every word that a stage does not compress, so all bits of an operand set move through the tree in step. When two words remain, one carry-propagate adder turns them into the final binary sum, and its output is registered. A new operand set may be presented on every clock. The valid strobe travels alongside the data with the same delay. There is no backpressure.

This is a pure datapath, so it has no state machine. The only control state is the shift register that carries the valid bit. A synchronous reset clears that shift register, and the data registers are not reset.

Top module: `mct_sum_tree`

## Requirements
- R1: `out_sum` is the exact sum of the `N` operands of one accepted set. It is `W + ceil(log2 N)` bits wide and never wraps. The final two-word addition never produces a carry beyond that width.
- R2: The latency is the number of compression stages plus one cycle. Each stage maps a count `c > 2` to `2*floor(c/4)` plus 2 when `c mod 4 = 3`, and plus `c mod 4` otherwise. For `N = 7` this is 7 to 4 to 2, which is two stages, so the latency is 3. `out_valid` equals `in_valid` delayed by exactly the latency.
- R3: The reset is synchronous and active high. After any rising edge with `rst` high, `out_valid` is 0, and operand sets already in flight never appear at the output.
- R4: When every operand is all ones, the result is `N*(2^W - 1)`, which is 1785 for `N = 7` and `W = 8`.
- R5: Each full-adder row keeps the value of its inputs. Its sum word plus its carry word, shifted one place up, equals the sum of its three inputs, and no carry leaves the top column.
- R6: Each four-to-two compressor feeds its first row's carry from bit i-1 into the second row at bit i. Its two outputs add up to the sum of its four inputs.
- R7: Each stage keeps the total value of its words from input to registered output. Words that are not compressed pass through exactly one register.
- R8: Operand sets may arrive on consecutive cycles or with gaps. Each valid set produces its own result, in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | The operand bus holds a set to be summed this cycle |
| in_ops | input | N*W | Operand k occupies bits `[k*W +: W]` |
| out_valid | output | 1 | `out_sum` holds the result of a set accepted latency cycles earlier |
| out_sum | output | W+ceil(log2 N) | Non-redundant sum of the operand set |

## Verification
The value-keeping checks inside the full-adder rows, compressors and stages are skipped while their operands are unknown. They therefore rely on the environment driving every operand bit to a defined level from the first cycle. The bench does this by initialising the bus at time zero and never releasing it. The in-flight counter assumes reset is applied before the first operand set. The bench holds `rst` high for several cycles before any valid input, and later asserts it once more while sets are in flight to confirm they are dropped.

// File: rtl/mct_pkg.sv
package mct_pkg;

    // Word count after one compression stage (4:2 groups, one 3:2 on a leftover of three).
    function automatic int reduce_once(input int c);
        if (c <= 2) return c;
        return 2 * (c / 4) + (((c % 4) == 3) ? 2 : (c % 4));
    endfunction

    // Word count entering stage s of a tree fed with n words.
    function automatic int level_count(input int n, input int s);
        int c;
        c = n;
        for (int k = 0; k < s; k++) c = reduce_once(c);
        return c;
    endfunction

    // Number of registered compression stages needed to reach two words.
    function automatic int stage_total(input int n);
        int c;
        int k;
        c = n;
        k = 0;
        while (c > 2) begin
            c = reduce_once(c);
            k++;
        end
        return k;
    endfunction

    // Word offset of level s inside the flat inter-stage bus.
    function automatic int level_offset(input int n, input int s);
        int o;
        o = 0;
        for (int k = 0; k < s; k++) o += level_count(n, k);
        return o;
    endfunction

endpackage

// File: rtl/mct_fa_row.sv
module mct_fa_row #(
    parameter int OW = 11
) (
    input  logic [OW-1:0] x,
    input  logic [OW-1:0] y,
    input  logic [OW-1:0] z,
    output logic [OW-1:0] s,
    output logic [OW-1:0] c
);
    localparam int EW = OW + 2;

    logic [OW-1:0] maj;

    assign s   = x ^ y ^ z;
    assign maj = (x & y) | (x & z) | (y & z);
    assign c   = {maj[OW-2:0], 1'b0};

    logic [EW-1:0] in_total;
    logic [EW-1:0] out_total;

    always_comb begin
        in_total  = EW'(x) + EW'(y) + EW'(z);
        out_total = EW'(s) + EW'(c);
        if (!$isunknown({x, y, z})) begin
            p_row_keeps_value_r5: assert (in_total == out_total);
            p_row_no_top_carry_r5: assert (maj[OW-1] == 1'b0);
        end
    end

endmodule

// File: rtl/mct_cmp42.sv
module mct_cmp42 #(
    parameter int OW = 11
) (
    input  logic [OW-1:0] a,
    input  logic [OW-1:0] b,
    input  logic [OW-1:0] c,
    input  logic [OW-1:0] d,
    output logic [OW-1:0] s,
    output logic [OW-1:0] k
);
    localparam int EW = OW + 3;

    logic [OW-1:0] s1;
    logic [OW-1:0] k1;

    // First level: three words in; its carry word arrives pre-shifted (bit i-1 -> bit i).
    mct_fa_row #(.OW(OW)) u_lvl1 (.x(a), .y(b), .z(c), .s(s1), .c(k1));
    // Second level: merges the first-level pair with the fourth word.
    mct_fa_row #(.OW(OW)) u_lvl2 (.x(s1), .y(k1), .z(d), .s(s), .c(k));

    logic [EW-1:0] in_total;
    logic [EW-1:0] out_total;

    always_comb begin
        in_total  = EW'(a) + EW'(b) + EW'(c) + EW'(d);
        out_total = EW'(s) + EW'(k);
        if (!$isunknown({a, b, c, d})) begin
            p_cmp_keeps_value_r6: assert (in_total == out_total);
        end
    end

endmodule

// File: rtl/mct_stage.sv
module mct_stage
    import mct_pkg::*;
#(
    parameter int OW = 11,
    parameter int NI = 7
) (
    input  logic                 clk,
    input  logic [NI*OW-1:0]     din,
    output logic [reduce_once(NI)*OW-1:0] dout
);
    localparam int NO  = reduce_once(NI);
    localparam int NG  = NI / 4;
    localparam int REM = NI % 4;
    localparam int SW  = OW + $clog2(NI + 1) + 2;

    logic [NO*OW-1:0] nxt;

    for (genvar g = 0; g < NG; g++) begin : g_quad
        mct_cmp42 #(.OW(OW)) u_cmp (
            .a (din[(4*g+0)*OW +: OW]),
            .b (din[(4*g+1)*OW +: OW]),
            .c (din[(4*g+2)*OW +: OW]),
            .d (din[(4*g+3)*OW +: OW]),
            .s (nxt[(2*g+0)*OW +: OW]),
            .k (nxt[(2*g+1)*OW +: OW])
        );
    end

    if (REM == 3) begin : g_tri
        mct_fa_row #(.OW(OW)) u_row (
            .x (din[(4*NG+0)*OW +: OW]),
            .y (din[(4*NG+1)*OW +: OW]),
            .z (din[(4*NG+2)*OW +: OW]),
            .s (nxt[(2*NG+0)*OW +: OW]),
            .c (nxt[(2*NG+1)*OW +: OW])
        );
    end else if (REM > 0) begin : g_pass
        for (genvar r = 0; r < REM; r++) begin : g_word
            assign nxt[(2*NG+r)*OW +: OW] = din[(4*NG+r)*OW +: OW];
        end
    end

    // Every word, compressed or passed through, crosses exactly one register here.
    always_ff @(posedge clk) begin
        dout <= nxt;
    end

    logic [SW-1:0] tin;
    logic [SW-1:0] tout;

    always_comb begin
        tin  = '0;
        tout = '0;
        for (int i = 0; i < NI; i++) tin  += SW'(din[i*OW +: OW]);
        for (int i = 0; i < NO; i++) tout += SW'(nxt[i*OW +: OW]);
        if (!$isunknown(din)) begin
            p_stage_keeps_value_r7: assert (tin == tout);
        end
    end

endmodule

// File: rtl/mct_cpa.sv
module mct_cpa #(
    parameter int OW = 11
) (
    input  logic          clk,
    input  logic [OW-1:0] a,
    input  logic [OW-1:0] b,
    output logic [OW-1:0] sum
);
    logic [OW:0] wide;

    assign wide = {1'b0, a} + {1'b0, b};

    always_ff @(posedge clk) begin
        sum <= wide[OW-1:0];
    end

    always_comb begin
        if (!$isunknown({a, b})) begin
            p_no_overflow_r1: assert (wide[OW] == 1'b0);
        end
    end

endmodule

// File: rtl/mct_sum_tree.sv
module mct_sum_tree
    import mct_pkg::*;
#(
    parameter int N = 7,
    parameter int W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [N*W-1:0]             in_ops,
    output logic                       out_valid,
    output logic [W+$clog2(N)-1:0]     out_sum
);
    localparam int OW  = W + $clog2(N);
    localparam int NS  = stage_total(N);
    localparam int LAT = NS + 1;
    localparam int FO  = level_offset(N, NS);
    localparam int TOT = FO + 2;
    localparam int IW  = $clog2(LAT + 2) + 1;

    // Flat bus holding every level of the tree, level 0 being the widened operands.
    logic [TOT*OW-1:0] bus;

    for (genvar i = 0; i < N; i++) begin : g_widen
        assign bus[i*OW +: OW] = {{(OW-W){1'b0}}, in_ops[i*W +: W]};
    end

    for (genvar s = 0; s < NS; s++) begin : g_stage
        localparam int CI = level_count(N, s);
        localparam int CO = level_count(N, s + 1);
        localparam int OI = level_offset(N, s);
        localparam int OO = level_offset(N, s + 1);
        mct_stage #(.OW(OW), .NI(CI)) u_stage (
            .clk  (clk),
            .din  (bus[OI*OW +: CI*OW]),
            .dout (bus[OO*OW +: CO*OW])
        );
    end

    mct_cpa #(.OW(OW)) u_cpa (
        .clk (clk),
        .a   (bus[FO*OW +: OW]),
        .b   (bus[(FO+1)*OW +: OW]),
        .sum (out_sum)
    );

    // Valid bit follows the data through the same number of registers.
    logic [LAT-1:0] vq;

    always_ff @(posedge clk) begin
        if (rst) vq <= '0;
        else     vq <= (vq << 1) | LAT'(in_valid);
    end

    assign out_valid = vq[LAT-1];

    // Assertion support: sets accepted but not yet delivered, and a delayed reset flag.
    logic [IW-1:0] inflight;
    logic          rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) inflight <= '0;
        else     inflight <= inflight + IW'(in_valid) - IW'(out_valid);
    end

    p_inflight_bound_r2: assert property (@(posedge clk) disable iff (rst)
        inflight <= IW'(LAT));

    p_valid_has_source_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (inflight != '0));

    p_reset_clears_r3: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> !out_valid);

endmodule

// File: tb/test_mct_sum_tree.sv
`timescale 1ns/1ps
module test_mct_sum_tree;
    localparam int N    = 7;
    localparam int W    = 8;
    localparam int OW   = W + $clog2(N);
    localparam int LAT  = 3;     // R2: 7 -> 4 -> 2 words, two stages plus the final adder
    localparam int ITER = 300;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [N*W-1:0] in_ops = '0;
    logic          out_valid;
    logic [OW-1:0] out_sum;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [OW-1:0] exp_sum  [ITER];
    bit            exp_v    [ITER];
    bit            all_ones [ITER];

    always #4 clk = ~clk;

    mct_sum_tree #(.N(N), .W(W)) i_mct_sum_tree (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ops    (in_ops),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    function automatic logic [OW-1:0] ref_sum(input logic [N*W-1:0] ops);
        int t;
        t = 0;
        for (int k = 0; k < N; k++) t += int'(ops[k*W +: W]);
        return OW'(t);
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [N*W-1:0] ones;
        void'($urandom(32'd4711));
        ones = '1;

        // R3: output stays invalid while reset is held
        repeat (3) @(negedge clk);
        check_bit("R3 valid during reset", out_valid, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < ITER + LAT; i++) begin
            if (i >= LAT) begin
                // R2 R8: valid mirrors input valid LAT cycles later
                check_bit("R2 R8 valid", out_valid, exp_v[i-LAT]);
                if (exp_v[i-LAT]) begin
                    if (all_ones[i-LAT])
                        check_word("R4 R1 all-ones sum", out_sum, exp_sum[i-LAT]);
                    else
                        check_word("R1 R5 R6 R7 R8 sum", out_sum, exp_sum[i-LAT]);
                end
            end else begin
                check_bit("R3 valid after reset", out_valid, 1'b0);
            end

            if (i < ITER) begin
                logic [N*W-1:0] ops;
                logic           v;
                for (int k = 0; k < N; k++) ops[k*W +: W] = W'($urandom);
                v = ($urandom % 4) != 0;
                all_ones[i] = 1'b0;
                if (i < 3) begin
                    ops = ones; v = 1'b1; all_ones[i] = 1'b1;
                end else if (i < 5) begin
                    ops = '0; v = 1'b1;
                end else if (i == 5) begin
                    ops = '0; ops[W-1:0] = '1; v = 1'b1;
                end else if (i % 13 == 0) begin
                    v = 1'b0;
                end else if (i % 29 == 0) begin
                    ops = ones; v = 1'b1; all_ones[i] = 1'b1;
                end
                in_ops   = ops;
                in_valid = v;
                exp_v[i]   = v;
                exp_sum[i] = ref_sum(ops);
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end

        // R3: sets in flight when reset hits must never emerge
        in_valid = 1'b1;
        in_ops   = ones;
        @(negedge clk);
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < LAT + 1; k++) begin
            check_bit("R3 flushed set", out_valid, 1'b0);
            @(negedge clk);
        end

        // R4: a fresh all-ones set after the reset is summed correctly
        in_valid = 1'b1;
        in_ops   = ones;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        check_bit("R2 valid after restart", out_valid, 1'b1);
        check_word("R4 all-ones after restart", out_sum, OW'(N * ((1 << W) - 1)));
        @(negedge clk);
        check_bit("R2 single pulse", out_valid, 1'b0);

        done = 1'b1;
        finish_run();
    end

endmodule